// File: doc/BRIEF.md
# PCI Power Management Capability Register Block

This block holds the power management capability structure that a PCI function exposes in its configuration space. The structure covers two dwords starting at a configurable capability base offset. The first dword holds the capability identifier, the link to the next capability and the read-only capability word. The second holds the control/status word, a bridge extension byte that always reads zero, and a power data byte. Configuration software reads and writes the structure through a dword-wide port with byte enables. The block reports the requested device power state and drives an active-low power-management event output.

Several side inputs shape what the registers report and which writes they accept. A power-management-enable strap gates the wake enable, the data select field and the data byte. A manageability strap gates the data scale field. An auxiliary-power indication decides whether the wake bits survive a bus reset. Two eight-bit power values, a next-pointer value and a clock-dependency strap fill the remaining fields. A single-cycle wake pulse from outside wake-detection logic raises the event status.

There are two reset domains. An asynchronous active-low power-good reset clears everything. The bus reset is synchronised and acts on its deasserting edge. The synchroniser is a two-state machine: HELD, where the synchronised bus reset is low, and RUN. The RELEASE transition (HELD to RUN) emits a one-cycle clear pulse, and the ASSERT transition (RUN to HELD) emits nothing. The power state is a second two-state machine, D0 and D3HOT. The SLEEP transition (D0 to D3HOT) happens on a write of 11b, and the WAKE transition (D3HOT to D0) happens on a write of 00b or on the clear pulse.

Top module: `pm_cap_regs`

## Requirements
- R1: The dword at the base reads 01h in bits 7:0 and the next-pointer input in bits 15:8. Its upper half is the capability word: version 010b in bits 2:0, 0 in bit 3, the clock strap in bit 4, 1 in bit 5, and 0 in bits 10:6.
- R2: Capability word bits 15:11 read 00000b with power management disabled. They read 01001b when it is enabled with auxiliary power 0, and 11001b when it is enabled with auxiliary power 1.
- R3: Control bits 1:0 accept writes of 00b (D0) and 11b (D3hot) and ignore writes of 01b and 10b. The `pwr_state` output equals this field.
- R4: The wake enable is control bit 8. Writing 0 clears it. Writing 1 sets it only when power management is enabled; otherwise the bit keeps its value.
- R5: The event status is control bit 15. A wake pulse sets it whatever the enable is. Writing 1 to it clears it, writing 0 leaves it, and a wake pulse in the same cycle as a clearing write wins.
- R6: `pme_n` is low exactly while both status and enable are 1. It goes high in the cycle after the edge at which a write of 1 clears the status.
- R7: The data select field, control bits 12:9, takes writes only when power management is enabled. Control bits 7:2 and bits 23:16 of the second dword always read 0.
- R8: Bits 31:24 of the second dword return the D0 value for select 0 or 4 and the D3 value for select 3 or 7. They return 0 for any other select, and 0 whenever power management is disabled.
- R9: The data scale field, control bits 14:13, reads 01b when manageability is enabled and the select is 0, 3, 4 or 7. Otherwise it reads 00b.
- R10: Power-good reset clears every writable field. A bus reset release clears the power state and the select. It clears the enable and the status only when auxiliary power is 0.
- R11: A byte address outside the two dwords reads as zero, and a write to it changes nothing.
- R12: A write changes only the fields in bytes whose enable bit is set. Byte 0 holds the power state, and byte 1 holds the enable, select and status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good_n | input | 1 | Asynchronous active-low power-good reset |
| bus_rst_n | input | 1 | Asynchronous active-low bus reset; its release clears fields |
| cfg_addr | input | 8 | Configuration byte address (dword-aligned use) |
| cfg_we | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| pm_en_strap | input | 1 | Power management enabled |
| mng_en_strap | input | 1 | Manageability enabled |
| aux_pwr | input | 1 | Auxiliary power present |
| d0_power | input | 8 | D0 power value |
| d3_power | input | 8 | D3 power value |
| next_ptr | input | 8 | Next capability pointer |
| pme_clk_strap | input | 1 | Event generation needs the bus clock |
| wake_evt | input | 1 | Single-cycle wake event pulse |
| pme_n | output | 1 | Active-low power management event |
| pwr_state | output | 2 | Current power state (00 D0, 11 D3hot) |

## Verification
Any wrong bit of the held state shows up in the very next read of the second dword: the power state, enable, select, status, scale and data byte all sit in that word. A wrong enable or status also shows on `pme_n` at once. A power state stuck in an ignored encoding would appear on `pwr_state` the cycle after the write. A bus reset mishandled in the wrong domain shows as a surviving or vanished wake bit a few cycles after the reset is released. The bench therefore reads back both dwords and the outputs after every stimulus cycle. It compares them with a model built from the requirements.

// File: rtl/pm_cap_pkg.sv
package pm_cap_pkg;

    typedef enum logic [1:0] {
        PS_D0    = 2'b00,
        PS_D3HOT = 2'b11
    } pstate_e;

    typedef enum logic {
        BR_HELD = 1'b0,
        BR_RUN  = 1'b1
    } brst_e;

    localparam logic [7:0] CAP_ID_PM  = 8'h01;
    localparam logic [2:0] PM_VERSION = 3'b010;
    localparam int         SEL_W      = 4;
    localparam int         PWR_W      = 8;

    function automatic logic [4:0] pme_support(input logic pm_on, input logic aux);
        if (!pm_on)  return 5'b00000;
        else if (aux) return 5'b11001;
        else          return 5'b01001;
    endfunction

    function automatic logic sel_reports(input logic [SEL_W-1:0] sel);
        return (sel == 4'd0) || (sel == 4'd3) || (sel == 4'd4) || (sel == 4'd7);
    endfunction

endpackage

// File: rtl/pm_busrst_edge.sv
module pm_busrst_edge
    import pm_cap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst_n,
    output logic clr_pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    brst_e state_q, state_d;
    logic  synced;
    logic  release_d;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], bus_rst_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BR_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        release_d = 1'b0;
        unique case (state_q)
            BR_HELD: if (synced) begin
                state_d   = BR_RUN;
                release_d = 1'b1;
            end
            BR_RUN: if (!synced) state_d = BR_HELD;
            default: state_d = BR_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_pulse <= 1'b0;
        else        clr_pulse <= release_d;
    end

    // R10
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !clr_pulse);

endmodule

// File: rtl/pm_pstate_fsm.sv
module pm_pstate_fsm
    import pm_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_clr,
    input  logic       wr,
    input  logic [1:0] req,
    output pstate_e    state
);

    pstate_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_D0;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        if (bus_clr) begin
            state_d = PS_D0;
        end else if (wr) begin
            unique case (state)
                PS_D0:    if (req == 2'b11) state_d = PS_D3HOT;
                PS_D3HOT: if (req == 2'b00) state_d = PS_D0;
                default:  state_d = PS_D0;
            endcase
        end
    end

    // R3
    mid_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !bus_clr && (req == 2'b01 || req == 2'b10)) |=> $stable(state));

endmodule

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clr,
    input  logic aux_pwr,
    input  logic pm_en_strap,
    input  logic wr_hi,
    input  logic en_bit,
    input  logic clr_bit,
    input  logic wake_evt,
    output logic pme_en_q,
    output logic pme_status_q,
    output logic pme_n
);

    logic soft_clr;
    assign soft_clr = bus_clr && !aux_pwr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                pme_en_q <= 1'b0;
        else if (soft_clr)                         pme_en_q <= 1'b0;
        else if (wr_hi && (!en_bit || pm_en_strap)) pme_en_q <= en_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pme_status_q <= 1'b0;
        else if (soft_clr)            pme_status_q <= 1'b0;
        else if (wake_evt)            pme_status_q <= 1'b1;
        else if (wr_hi && clr_bit)    pme_status_q <= 1'b0;
    end

    assign pme_n = ~(pme_status_q & pme_en_q);

    // R4
    en_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pm_en_strap && !pme_en_q) |=> !pme_en_q);

    // R5
    wake_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_evt && !soft_clr) |=> pme_status_q);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && clr_bit && !wake_evt) |=> pme_n);

    // R10
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_clr && aux_pwr && !wr_hi && !wake_evt) |=> ($stable(pme_en_q) && $stable(pme_status_q)));

endmodule

// File: rtl/pm_cap_regs.sv
module pm_cap_regs
    import pm_cap_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CAP_BASE    = 8'hDC,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              pwr_good_n,
    input  logic              bus_rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              pm_en_strap,
    input  logic              mng_en_strap,
    input  logic              aux_pwr,
    input  logic [PWR_W-1:0]  d0_power,
    input  logic [PWR_W-1:0]  d3_power,
    input  logic [7:0]        next_ptr,
    input  logic              pme_clk_strap,
    input  logic              wake_evt,
    output logic              pme_n,
    output logic [1:0]        pwr_state
);

    localparam int                  IDX_W   = ADDR_W - 2;
    localparam logic [IDX_W-1:0]    BASE_DW = CAP_BASE[ADDR_W-1:2];
    localparam logic [IDX_W-1:0]    NEXT_DW = BASE_DW + 1'b1;

    logic             hit0, hit1, wr_lo, wr_hi;
    logic             bus_clr;
    logic             pme_en_q, pme_status_q;
    logic [SEL_W-1:0] sel_q;
    pstate_e          ps_q;
    logic [15:0]      pmc_word, pmcsr_word;
    logic [1:0]       scale;
    logic [PWR_W-1:0] data_byte;
    logic             wdata_unused;

    assign hit0  = (cfg_addr[ADDR_W-1:2] == BASE_DW);
    assign hit1  = (cfg_addr[ADDR_W-1:2] == NEXT_DW);
    assign wr_lo = cfg_we && hit1 && cfg_be[0];
    assign wr_hi = cfg_we && hit1 && cfg_be[1];
    assign wdata_unused = ^{cfg_wdata[31:16], cfg_wdata[7:2], cfg_addr[1:0], cfg_be[3:2]};

    pm_busrst_edge #(.SYNC_STAGES(SYNC_STAGES)) u_brst (
        .clk       (clk),
        .rst_n     (pwr_good_n),
        .bus_rst_n (bus_rst_n),
        .clr_pulse (bus_clr)
    );

    pm_pstate_fsm u_ps (
        .clk     (clk),
        .rst_n   (pwr_good_n),
        .bus_clr (bus_clr),
        .wr      (wr_lo),
        .req     (cfg_wdata[1:0]),
        .state   (ps_q)
    );

    pm_wake_ctl u_wake (
        .clk          (clk),
        .rst_n        (pwr_good_n),
        .bus_clr      (bus_clr),
        .aux_pwr      (aux_pwr),
        .pm_en_strap  (pm_en_strap),
        .wr_hi        (wr_hi),
        .en_bit       (cfg_wdata[8]),
        .clr_bit      (cfg_wdata[15]),
        .wake_evt     (wake_evt),
        .pme_en_q     (pme_en_q),
        .pme_status_q (pme_status_q),
        .pme_n        (pme_n)
    );

    always_ff @(posedge clk or negedge pwr_good_n) begin
        if (!pwr_good_n)            sel_q <= '0;
        else if (bus_clr)           sel_q <= '0;
        else if (wr_hi && pm_en_strap) sel_q <= cfg_wdata[12:9];
    end

    always_comb begin
        scale     = {1'b0, mng_en_strap && sel_reports(sel_q)};
        data_byte = '0;
        if (pm_en_strap) begin
            unique case (sel_q)
                4'd0, 4'd4: data_byte = d0_power;
                4'd3, 4'd7: data_byte = d3_power;
                default:    data_byte = '0;
            endcase
        end
        pmc_word   = {pme_support(pm_en_strap, aux_pwr), 2'b00, 3'b000,
                      1'b1, pme_clk_strap, 1'b0, PM_VERSION};
        pmcsr_word = {pme_status_q, scale, sel_q, pme_en_q, 6'b0, ps_q};
    end

    always_comb begin
        if (hit0)      cfg_rdata = {pmc_word, next_ptr, CAP_ID_PM};
        else if (hit1) cfg_rdata = {data_byte, 8'h00, pmcsr_word};
        else           cfg_rdata = '0;
    end

    assign pwr_state = ps_q;

    // R11
    outside_zero_chk: assert property (@(posedge clk) disable iff (!pwr_good_n)
        (!hit0 && !hit1) |-> (cfg_rdata == 32'h0));

    // R8
    data_gated_chk: assert property (@(posedge clk) disable iff (!pwr_good_n)
        !pm_en_strap |-> (cfg_rdata[31:24] == 8'h00));

    // R7
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!pwr_good_n)
        (!pm_en_strap && !bus_clr) |=> $stable(sel_q));

endmodule

// File: tb/pm_cap_regs_test.sv
module pm_cap_regs_test;

    logic        clk = 1'b0;
    logic        pwr_good_n = 1'b0;
    logic        bus_rst_n = 1'b1;
    logic [7:0]  cfg_addr = 8'h00;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        pm_en = 1'b1, mng_en = 1'b1, aux = 1'b0, pclk = 1'b1, wake = 1'b0;
    logic [7:0]  d0v = 8'h5A, d3v = 8'hC3, nptr = 8'hE8;
    logic        pme_n;
    logic [1:0]  pwr_state;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [1:0]  m_ps;
    logic        m_en, m_st;
    logic [3:0]  m_sel;

    localparam logic [7:0] DW0 = 8'hDC, DW1 = 8'hE0;

    always #10 clk = ~clk;

    pm_cap_regs uut (
        .clk(clk), .pwr_good_n(pwr_good_n), .bus_rst_n(bus_rst_n),
        .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pm_en_strap(pm_en), .mng_en_strap(mng_en), .aux_pwr(aux),
        .d0_power(d0v), .d3_power(d3v), .next_ptr(nptr),
        .pme_clk_strap(pclk), .wake_evt(wake),
        .pme_n(pme_n), .pwr_state(pwr_state)
    );

    function automatic logic [31:0] exp_dw0();
        logic [4:0] sup;
        sup = !pm_en ? 5'b00000 : (aux ? 5'b11001 : 5'b01001);
        return {sup, 5'b00000, 1'b1, pclk, 1'b0, 3'b010, nptr, 8'h01};
    endfunction

    function automatic logic [31:0] exp_dw1();
        logic [7:0] db;
        logic       sc;
        sc = mng_en && (m_sel == 0 || m_sel == 3 || m_sel == 4 || m_sel == 7);
        db = 8'h00;
        if (pm_en && (m_sel == 0 || m_sel == 4)) db = d0v;
        if (pm_en && (m_sel == 3 || m_sel == 7)) db = d3v;
        return {db, 8'h00, m_st, 1'b0, sc, m_sel, m_en, 6'b0, m_ps};
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        cfg_addr = DW1; #1;
        check32({tag, " dword1"}, cfg_rdata, exp_dw1());
        cfg_addr = DW0; #1;
        check32({tag, " R1 R2 dword0"}, cfg_rdata, exp_dw0());
        check32({tag, " R6 pme_n"}, {31'b0, pme_n}, {31'b0, !(m_st && m_en)});
        check32({tag, " R3 pwr_state"}, {30'b0, pwr_state}, {30'b0, m_ps});
    endtask

    task automatic cyc(logic we, logic [7:0] a, logic [3:0] be, logic [31:0] wd, logic wk);
        cfg_we = we; cfg_addr = a; cfg_be = be; cfg_wdata = wd; wake = wk;
        @(posedge clk);
        if (we && a[7:2] == DW1[7:2]) begin
            if (be[0] && (wd[1:0] == 2'b00 || wd[1:0] == 2'b11)) m_ps = wd[1:0];
            if (be[1]) begin
                if (!wd[8]) m_en = 1'b0;
                else if (pm_en) m_en = 1'b1;
                if (pm_en) m_sel = wd[12:9];
                if (wd[15]) m_st = 1'b0;
            end
        end
        if (wk) m_st = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; wake = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, DW1, 4'h0, 32'h0, 1'b0);
    endtask

    task automatic bus_reset();
        bus_rst_n = 1'b0;
        idle(4);
        bus_rst_n = 1'b1;
        idle(6);
        m_ps = 2'b00; m_sel = 4'h0;
        if (!aux) begin m_en = 1'b0; m_st = 1'b0; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_ps = 0; m_en = 0; m_st = 0; m_sel = 0;
        repeat (3) @(negedge clk);
        pwr_good_n = 1'b1;
        idle(8);
        chk_all("R10 power-good reset");

        aux = 1'b1; #1; chk_all("R2 aux on");
        pm_en = 1'b0; #1; chk_all("R2 pm off R8");
        pm_en = 1'b1; aux = 1'b0;

        cyc(1, DW1, 4'h1, 32'h3, 0); chk_all("R3 write D3hot");
        cyc(1, DW1, 4'h1, 32'h1, 0); chk_all("R3 ignore 01");
        cyc(1, DW1, 4'h1, 32'h2, 0); chk_all("R3 ignore 10");
        cyc(1, DW1, 4'h1, 32'h0, 0); chk_all("R3 write D0");

        pm_en = 1'b0;
        cyc(1, DW1, 4'h2, 32'h100, 0); chk_all("R4 enable blocked");
        cyc(1, DW1, 4'h2, 32'h0600, 0); chk_all("R7 select blocked");
        pm_en = 1'b1;
        cyc(1, DW1, 4'h2, 32'h100, 0); chk_all("R4 enable set");

        cyc(0, DW1, 4'h0, 32'h0, 1); chk_all("R5 R6 wake asserts");
        cyc(1, DW1, 4'h2, 32'h0100, 0); chk_all("R5 write 0 keeps");
        cyc(1, DW1, 4'h2, 32'h8100, 1); chk_all("R5 wake wins");
        cyc(1, DW1, 4'h2, 32'h8100, 0); chk_all("R5 R6 clear releases");
        cyc(1, DW1, 4'h2, 32'h0000, 0);
        cyc(0, DW1, 4'h0, 32'h0, 1); chk_all("R5 wake without enable");

        cyc(1, DW1, 4'h2, 32'h0600, 0); chk_all("R7 R8 R9 select 3");
        cyc(1, DW1, 4'h2, 32'h0A00, 0); chk_all("R8 R9 select 5");
        cyc(1, DW1, 4'h2, 32'h0800, 0); mng_en = 1'b0; #1; chk_all("R9 manage off select 4");
        mng_en = 1'b1;

        cyc(1, DW1, 4'hC, 32'hFFFF_FFFF, 0); chk_all("R12 no byte enable");
        cyc(1, DW1, 4'h1, 32'hFFFF_FF03, 0); chk_all("R12 byte0 only");
        cyc(1, 8'hE4, 4'hF, 32'hFFFF_FFFF, 0);
        cyc(1, 8'hD8, 4'hF, 32'h0000_0000, 0); chk_all("R11 outside writes");
        cfg_addr = 8'hE4; #1; check32("R11 outside read", cfg_rdata, 32'h0);

        cyc(1, DW1, 4'h2, 32'h0300, 0); cyc(0, DW1, 4'h0, 32'h0, 1);
        aux = 1'b1; bus_reset(); chk_all("R10 bus reset aux on");
        aux = 1'b0; bus_reset(); chk_all("R10 bus reset aux off");

        for (int it = 0; it < 400; it++) begin
            logic [7:0] a;
            logic [1:0] r;
            pm_en  = ($urandom % 4) != 0;
            mng_en = $urandom % 2;
            aux    = $urandom % 2;
            d0v    = 8'($urandom);
            d3v    = 8'($urandom);
            r      = 2'($urandom);
            a      = (r == 0) ? DW0 : ((r == 1) ? 8'($urandom) : DW1);
            cyc(($urandom % 2) == 1, a, 4'($urandom), $urandom, ($urandom % 8) == 0);
            chk_all("R3 R4 R5 R7 R8 R9 R12 random");
            if (it % 80 == 79) begin
                bus_reset();
                chk_all("R10 random bus reset");
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule